// File: doc/BRIEF.md
# Programmable-Modulus Third-Order Fractional Divide Modulator

This block chooses, one reference cycle at a time, the division ratio that a fractional-N synthesizer's feedback divider uses. Software-visible settings are an integer part, a fraction numerator and a runtime modulus, which together with a dither-enable bit are applied as one set by an update strobe. On every cycle where the phase-detector enable is high, the block advances a cascade of three accumulators. Each accumulator wraps at the programmed modulus. The block outputs a small signed offset and the ratio formed by adding that offset to the integer part. Over time the ratio averages to integer plus fraction divided by modulus.

With dither off, the output pattern is fully deterministic. Its period depends on whether the modulus is divisible by 2, by 3, or by 6. With dither on, a long pseudo-random bit is injected into the first stage so that the pattern loses its short period. A legality check refuses any setting set that the modulator cannot run, and the previous settings stay active when that happens.

Top module: `frac_sdm_top`

## Requirements
- R1: After synchronous reset, divOffset is 0, divRatio is 0 and cfgIllegal is 0.
- R2: An update is legal only if cfgMod is at least 2 (the field is 12 bits wide, so values up to 4095 are allowed) and cfgFrac is less than cfgMod. An illegal update sets cfgIllegal to 1 from the next cycle and leaves the active settings and the modulator state untouched. A legal update clears cfgIllegal.
- R3: With cfgDither set to 1, an update with cfgMod below 50 is illegal. An update with cfgMod of 50 or more is legal.
- R4: A legal update clears all accumulators, carry history and the offset. In the following cycle divOffset is 0 and divRatio equals the new cfgInt. The next step then starts the sequence from the all-zero state.
- R5: The modulator advances only on edges where phaseEn is 1 and cfgLoad is 0. On any other edge, divOffset and divRatio hold their values.
- R6: With dither off, each step updates each stage as acc = (acc + input) mod cfgMod, where the carry is 1 when a wrap occurs. Stage 1 adds the fraction. Stage k adds the new value of stage k-1. The output is divOffset = c1 + (c2 - c2') + (c3 - 2*c3' + c3''), where a prime marks the value from the previous step. divOffset is a 4-bit two's-complement value in -3..+4. divRatio = cfgInt + divOffset.
- R7: With dither off and cfgFrac coprime to cfgMod, the sum of divOffset over one full period L is exactly cfgFrac*L/cfgMod.
- R8: With dither off and cfgFrac coprime to cfgMod, the output period L depends on the modulus M as follows. L is 2M for M even and not a multiple of 3. L is 3M for M odd and a multiple of 3. L is 6M for M a multiple of 6. L is M otherwise.
- R9: With dither on, the least significant bit of a 21-bit maximal-length shift register (taps 21 and 19, never all-zero) is added to the first-stage input on every step. divOffset stays in -3..+4, and the pattern no longer repeats at the dither-off period.
- R10: With cfgFrac equal to 0 and dither off, divOffset stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phaseEn | input | 1 | One pulse per phase-detector cycle; advances the modulator |
| cfgLoad | input | 1 | Update strobe; applies the four setting inputs together |
| cfgInt | input | 16 | Integer part of the divide ratio |
| cfgFrac | input | 12 | Fraction numerator |
| cfgMod | input | 12 | Modulus |
| cfgDither | input | 1 | Dither enable |
| divOffset | output | 4 | Signed per-cycle offset, -3..+4 |
| divRatio | output | 16 | Instantaneous divide value, cfgInt + divOffset |
| cfgIllegal | output | 1 | Last update was refused |

## Verification
The bench runs one modulus from each divisibility class and then measures the repeat length of the dither-off output. An accumulator that wrapped at a power of two, or a combiner with a wrong delay tap, would give the wrong period or a drifting sum over the period. Updates are sent with modulus below 2, with the fraction equal to the modulus, and with dither on at moduli 49 and 50. A design that loaded a refused setting would restart or change its sequence and break step-by-step agreement with the reference. Gapped enables and mid-run reloads show whether a design advances on idle edges or fails to restart from the zero state.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int ACC_W  = 12;
  localparam int INT_W  = 16;
  localparam int OFS_W  = 4;
  localparam int STAGES = 3;

  typedef logic [ACC_W-1:0] acc_t;

  typedef struct packed {
    logic [INT_W-1:0] intVal;
    acc_t             fracVal;
    acc_t             modVal;
    logic             dither;
  } sdm_cfg_t;

  typedef struct packed {
    logic step;
    logic clear;
  } sdm_strobe_t;
endpackage

// File: rtl/sdm_lfsr.sv
module sdm_lfsr #(
  parameter int             WIDTH = 21,
  parameter logic [WIDTH-1:0] TAPS  = 21'h140000,
  parameter logic [WIDTH-1:0] SEED  = 21'h000001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [WIDTH-1:0] state
);
  logic feedback;
  assign feedback = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst)          state <= SEED;
    else if (advance) state <= {state[WIDTH-2:0], feedback};
  end

  // R9
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("lfsr reached all-zero state");
endmodule

// File: rtl/sdm_accum.sv
module sdm_accum
  import sdm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clear,
  input  acc_t modVal,
  input  acc_t addend,
  output acc_t accQ,
  output acc_t accNext,
  output logic carry
);
  logic [ACC_W:0] rawSum;
  logic [ACC_W:0] wrapped;

  always_comb begin
    rawSum  = {1'b0, accQ} + {1'b0, addend};
    carry   = (rawSum >= {1'b0, modVal});
    wrapped = rawSum - {1'b0, modVal};
    accNext = carry ? wrapped[ACC_W-1:0] : rawSum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) accQ <= '0;
    else if (step)    accQ <= accNext;
  end

  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst) accQ < modVal)
    else $error("accumulator not below modulus");
endmodule

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
#(
  parameter int DITHER_MIN_MOD = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        phaseEn,
  input  logic        cfgLoad,
  input  sdm_cfg_t    cfgIn,
  output sdm_cfg_t    cfgReg,
  output sdm_strobe_t strobe,
  output logic        cfgIllegal
);
  localparam acc_t MIN_MOD  = acc_t'(2);
  localparam acc_t DITH_MIN = acc_t'(DITHER_MIN_MOD);

  logic modOk, fracOk, ditherOk, isLegal;

  always_comb begin
    modOk    = cfgIn.modVal >= MIN_MOD;
    fracOk   = cfgIn.fracVal < cfgIn.modVal;
    ditherOk = !cfgIn.dither || (cfgIn.modVal >= DITH_MIN);
    isLegal  = modOk && fracOk && ditherOk;
  end

  assign strobe.clear = cfgLoad && isLegal;
  assign strobe.step  = phaseEn && !cfgLoad;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg.intVal  <= '0;
      cfgReg.fracVal <= '0;
      cfgReg.modVal  <= MIN_MOD;
      cfgReg.dither  <= 1'b0;
      cfgIllegal     <= 1'b0;
    end else if (cfgLoad) begin
      if (isLegal) begin
        cfgReg     <= cfgIn;
        cfgIllegal <= 1'b0;
      end else begin
        cfgIllegal <= 1'b1;
      end
    end
  end

  // R3
  dither_min_chk: assert property (@(posedge clk) disable iff (rst)
    cfgReg.dither |-> (cfgReg.modVal >= DITH_MIN))
    else $error("dither active with small modulus");

  // R2
  frac_range_chk: assert property (@(posedge clk) disable iff (rst)
    cfgReg.fracVal < cfgReg.modVal)
    else $error("active fraction not below modulus");

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgLoad && !isLegal) |=> (cfgIllegal && $stable(cfgReg)))
    else $error("refused update changed settings");
endmodule

// File: rtl/sdm_datapath.sv
module sdm_datapath
  import sdm_pkg::*;
#(
  parameter int               LFSR_W    = 21,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 21'h140000,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 21'h000001
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sdm_cfg_t                cfg,
  input  sdm_strobe_t             strobe,
  output logic signed [OFS_W-1:0] divOffset,
  output logic [INT_W-1:0]        divRatio
);
  acc_t stageIn   [STAGES];
  acc_t stageQ    [STAGES];
  acc_t stageNext [STAGES];
  logic stageCarry[STAGES];

  logic [LFSR_W-1:0] lfsrState;
  logic              ditherBit;

  sdm_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) lfsr_i (
    .clk    (clk),
    .rst    (rst),
    .advance(strobe.step),
    .state  (lfsrState)
  );

  assign ditherBit = cfg.dither & lfsrState[0];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stageIn[g] = cfg.fracVal + acc_t'(ditherBit);
    end else begin : g_chain
      assign stageIn[g] = stageNext[g-1];
    end
    sdm_accum accum_i (
      .clk    (clk),
      .rst    (rst),
      .step   (strobe.step),
      .clear  (strobe.clear),
      .modVal (cfg.modVal),
      .addend (stageIn[g]),
      .accQ   (stageQ[g]),
      .accNext(stageNext[g]),
      .carry  (stageCarry[g])
    );
  end

  logic c2Prev, c3Prev, c3Prev2;
  logic signed [OFS_W-1:0] offsetNext;

  always_comb begin
    int sum;
    sum = int'(stageCarry[0])
        + int'(stageCarry[1]) - int'(c2Prev)
        + int'(stageCarry[2]) - 2 * int'(c3Prev) + int'(c3Prev2);
    offsetNext = OFS_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      c2Prev    <= 1'b0;
      c3Prev    <= 1'b0;
      c3Prev2   <= 1'b0;
      divOffset <= '0;
    end else if (strobe.step) begin
      c2Prev    <= stageCarry[1];
      c3Prev    <= stageCarry[2];
      c3Prev2   <= c3Prev;
      divOffset <= offsetNext;
    end
  end

  assign divRatio = cfg.intVal + {{(INT_W-OFS_W){divOffset[OFS_W-1]}}, divOffset};

  // R6
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    (divOffset >= -4'sd3) && (divOffset <= 4'sd4))
    else $error("offset out of range");

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.step && !strobe.clear) |=> $stable(divOffset))
    else $error("offset moved without step");

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (divOffset == '0))
    else $error("offset not cleared by update");
endmodule

// File: rtl/frac_sdm_top.sv
module frac_sdm_top
  import sdm_pkg::*;
#(
  parameter int               DITHER_MIN_MOD = 50,
  parameter int               LFSR_W         = 21,
  parameter logic [LFSR_W-1:0] LFSR_TAPS      = 21'h140000,
  parameter logic [LFSR_W-1:0] LFSR_SEED      = 21'h000001
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    phaseEn,
  input  logic                    cfgLoad,
  input  logic [INT_W-1:0]        cfgInt,
  input  logic [ACC_W-1:0]        cfgFrac,
  input  logic [ACC_W-1:0]        cfgMod,
  input  logic                    cfgDither,
  output logic signed [OFS_W-1:0] divOffset,
  output logic [INT_W-1:0]        divRatio,
  output logic                    cfgIllegal
);
  sdm_cfg_t    cfgIn, cfgReg;
  sdm_strobe_t strobe;

  assign cfgIn.intVal  = cfgInt;
  assign cfgIn.fracVal = cfgFrac;
  assign cfgIn.modVal  = cfgMod;
  assign cfgIn.dither  = cfgDither;

  sdm_ctrl #(.DITHER_MIN_MOD(DITHER_MIN_MOD)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .phaseEn   (phaseEn),
    .cfgLoad   (cfgLoad),
    .cfgIn     (cfgIn),
    .cfgReg    (cfgReg),
    .strobe    (strobe),
    .cfgIllegal(cfgIllegal)
  );

  sdm_datapath #(.LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfgReg),
    .strobe   (strobe),
    .divOffset(divOffset),
    .divRatio (divRatio)
  );
endmodule

// File: tb/frac_sdm_top_tb_top.sv
module frac_sdm_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phaseEn = 1'b0;
  logic cfgLoad = 1'b0;
  logic [15:0] cfgInt = '0;
  logic [11:0] cfgFrac = '0;
  logic [11:0] cfgMod = '0;
  logic cfgDither = 1'b0;
  logic signed [3:0] divOffset;
  logic [15:0] divRatio;
  logic cfgIllegal;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // behavioural reference state
  int mM, mF, mInt;
  int mA1, mA2, mA3, mC2d, mC3d, mC3dd;
  int lastY;
  bit ditherOn;
  int hist[$];

  always #10 clk = ~clk;

  frac_sdm_top dut_i (
    .clk(clk), .rst(rst), .phaseEn(phaseEn), .cfgLoad(cfgLoad),
    .cfgInt(cfgInt), .cfgFrac(cfgFrac), .cfgMod(cfgMod), .cfgDither(cfgDither),
    .divOffset(divOffset), .divRatio(divRatio), .cfgIllegal(cfgIllegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelClear();
    mA1 = 0; mA2 = 0; mA3 = 0; mC2d = 0; mC3d = 0; mC3dd = 0; lastY = 0;
    hist.delete();
  endtask

  task automatic modelStep(output int y);
    int s, c1, c2, c3;
    s = mA1 + mF;  c1 = s / mM; mA1 = s % mM;
    s = mA2 + mA1; c2 = s / mM; mA2 = s % mM;
    s = mA3 + mA2; c3 = s / mM; mA3 = s % mM;
    y = c1 + c2 - mC2d + c3 - 2 * mC3d + mC3dd;
    mC2d = c2; mC3dd = mC3d; mC3d = c3;
  endtask

  // one cycle starting and ending at a negedge
  task automatic cycle(input bit en);
    int y, act;
    phaseEn = en;
    @(posedge clk);
    @(negedge clk);
    phaseEn = 1'b0;
    act = int'(divOffset);
    if (en) begin
      hist.push_back(act);
      if (ditherOn) begin
        check(act >= -3 && act <= 4, "R9 offset range with dither", act, 0);
      end else begin
        modelStep(y);
        lastY = y;
        check(act == y, "R6 offset vs reference", act, y);
        check(int'(divRatio) == mInt + y, "R6 ratio vs reference", int'(divRatio), mInt + y);
      end
    end else begin
      check(act == lastY, "R5 hold without enable", act, lastY);
    end
  endtask

  task automatic load(input int iv, input int fv, input int mv, input bit dv);
    bit legal;
    legal = (mv >= 2) && (fv < mv) && (!dv || mv >= 50);
    cfgLoad = 1'b1; cfgInt = 16'(iv); cfgFrac = 12'(fv); cfgMod = 12'(mv); cfgDither = dv;
    phaseEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfgLoad = 1'b0; phaseEn = 1'b0;
    if (dv && mv < 50) check(cfgIllegal == !legal, "R3 dither small modulus flag", int'(cfgIllegal), int'(!legal));
    else               check(cfgIllegal == !legal, "R2 legality flag", int'(cfgIllegal), int'(!legal));
    if (legal) begin
      mInt = iv; mF = fv; mM = mv; ditherOn = dv;
      modelClear();
      check(int'(divOffset) == 0, "R4 offset cleared on update", int'(divOffset), 0);
      check(int'(divRatio) == iv, "R4 ratio equals new integer", int'(divRatio), iv);
    end else begin
      check(int'(divOffset) == lastY, "R2 refused update keeps output", int'(divOffset), lastY);
    end
  endtask

  function automatic int expPeriod(input int m);
    if (m % 6 == 0) return 6 * m;
    if (m % 2 == 0) return 2 * m;
    if (m % 3 == 0) return 3 * m;
    return m;
  endfunction

  function automatic int findPeriod(input int start, input int maxL);
    for (int l = 1; l <= maxL; l++) begin
      bit same = 1;
      for (int k = start; k < start + maxL; k++)
        if (hist[k] != hist[k + l]) begin same = 0; break; end
      if (same) return l;
    end
    return -1;
  endfunction

  task automatic periodRun(input int mv, input int fv);
    int maxL, l, sum;
    load(200, fv, mv, 1'b0);
    maxL = 6 * mv;
    for (int i = 0; i < 10 + 2 * maxL + 4; i++) cycle(1'b1);
    l = findPeriod(10, maxL);
    check(l == expPeriod(mv), "R8 period by modulus class", l, expPeriod(mv));
    if (l > 0) begin
      sum = 0;
      for (int k = 10; k < 10 + l; k++) sum += hist[k];
      check(sum * mv == fv * l, "R7 exact mean over period", sum * mv, fv * l);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    bit differs;
    ditherOn = 0; mInt = 0; mF = 0; mM = 2;
    modelClear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(int'(divOffset) == 0, "R1 reset offset", int'(divOffset), 0);
    check(int'(divRatio) == 0, "R1 reset ratio", int'(divRatio), 0);
    check(cfgIllegal == 1'b0, "R1 reset flag", int'(cfgIllegal), 0);

    // R10 zero fraction
    load(40, 0, 7, 1'b0);
    for (int i = 0; i < 20; i++) begin
      cycle(1'b1);
      check(int'(divOffset) == 0, "R10 zero fraction", int'(divOffset), 0);
    end

    // R8 / R7 one modulus per class
    periodRun(10, 3);
    periodRun(9, 2);
    periodRun(12, 5);
    periodRun(7, 3);
    periodRun(100, 37);

    // R5 gapped enables
    load(64, 4, 13, 1'b0);
    for (int i = 0; i < 40; i++) cycle(i % 2 == 0);

    // R2 refused updates keep running sequence
    load(70, 1, 1, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1);
    load(70, 13, 13, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1);
    // R3 dither with modulus 49 refused
    load(70, 5, 49, 1'b1);
    for (int i = 0; i < 6; i++) cycle(1'b1);

    // R4 mid-run reload restarts from zero state
    load(64, 4, 13, 1'b0);
    for (int i = 0; i < 30; i++) cycle(1'b1);

    // R3 / R9 dither accepted at modulus 50
    load(300, 17, 50, 1'b1);
    check(cfgIllegal == 1'b0, "R3 modulus 50 with dither accepted", int'(cfgIllegal), 0);
    for (int i = 0; i < 1200; i++) cycle(1'b1);
    differs = 0;
    for (int k = 10; k < 1000; k++) if (hist[k] != hist[k + 100]) differs = 1;
    check(differs, "R9 dither breaks short period", int'(differs), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule